// File: doc/BRIEF.md
# Three-Slot Lookahead Instruction Buffer

This block sits in the decode stage of a core that runs 16-bit instructions fetched as 32-bit words. It stores up to three consecutive 16-bit instructions. Each cycle it offers the oldest one (slot 1) to the decompressor and the next one (slot 2) to the logic that handles an augmenting prefix. When slot 2 holds a prefix, the prefix and the instruction ahead of it leave together in one cycle. Otherwise only slot 1 leaves. The survivors move up so that the oldest pending instruction is always in slot 1. A fresh fetch word is accepted only when the entries left after this cycle's consumption leave room for both halves.

The third slot exists so that a prefix can be present at the same moment as the instruction it follows. Without it, the prefix would arrive one fetch later and would cost a cycle. A taken branch raises the flush input. The flush empties the buffer, and the first word fetched afterwards lands in slots 1 and 2. Code is expected never to place a prefix at a branch target, so an instruction in slot 1 is always handled as an ordinary one.

Occupancy is held by six named states. OCC_EMPTY holds nothing. OCC_ONE holds one ordinary instruction. OCC_TWO_PLAIN holds two ordinary instructions. OCC_TWO_PFX holds an ordinary instruction followed by a prefix. OCC_THREE_PLAIN holds three ordinary instructions. OCC_THREE_PFX holds ordinary, prefix, ordinary.

Each transition has a name:
- drain: consume with no deposit, so the occupancy falls.
- refill: consume, then deposit into slots 1 and 2 when nothing remains.
- top-up: consume, then deposit into slots 2 and 3 when one entry remains.
- hold: OCC_EMPTY with nothing fetched, so the buffer stays empty.
- flush: any state to OCC_EMPTY.

After every transition the buffer lands in the plain or prefix state for its new count, chosen by the instruction that now sits in slot 2.

Top module: `lookahead_ibuf`

## Requirements
- R1: After reset the buffer is empty. slot1_valid_o, slot2_valid_o and pair_take_o are 0, and fetch_req_o is 1.
- R2: An instruction is a prefix when its bits [15:8] equal 8'hDE. pair_take_o is 1 in exactly those cycles in which slot 2 is valid and holds a prefix.
- R3: Within a fetch word, bits [15:0] are the earlier instruction. A word accepted while no entry remains appears in the next cycle with bits [15:0] in slot 1 and bits [31:16] in slot 2.
- R4: When pair_take_o is 0 and slot 1 is valid, exactly one entry is consumed. In the next cycle, slot 1 holds what was in slot 2.
- R5: When pair_take_o is 1, slots 1 and 2 are both consumed. In the next cycle, slot 1 holds the former slot 3 or, if slot 3 was empty, the lower half of the word accepted in that cycle.
- R6: fetch_req_o is 1 exactly when at most one entry remains after this cycle's consumption. A word presented while fetch_req_o is 0 changes nothing.
- R7: A word accepted while one entry remains fills slots 2 and 3, lower half first, behind the surviving entry.
- R8: flush_i empties the buffer at the next edge. It overrides both the consumption and the deposit of that cycle, and a word presented in that cycle is dropped.
- R9: An instruction in slot 1 is always treated as ordinary. A prefix-coded instruction landing in slot 1 neither raises pair_take_o nor takes a second entry with it.
- R10: With no fetch words arriving, the buffer drains one instruction per cycle to empty, then stays empty with slot1_valid_o at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Taken-branch flush; empties the buffer |
| fetch_valid_i | input | 1 | A fetch word is offered this cycle |
| fetch_word_i | input | 32 | Two instructions; bits [15:0] are the earlier one |
| fetch_req_o | output | 1 | Buffer can take a word at this edge |
| slot1_valid_o | output | 1 | Slot 1 holds an instruction |
| slot1_instr_o | output | 16 | Instruction for the decompressor |
| slot2_valid_o | output | 1 | Slot 2 holds an instruction |
| slot2_instr_o | output | 16 | Instruction for the prefix handler |
| pair_take_o | output | 1 | Slot 2 is a prefix; both slots leave this cycle |

## Verification
The bench creates cycles in which consumption and deposit happen together. In the first, a prefix pair is consumed from OCC_THREE_PFX while a new word is taken in, and the bench checks that the old slot 3 becomes slot 1 with the new halves behind it. In the second, a single entry leaves OCC_TWO_PLAIN while a word tops the buffer up to three. The bench also raises a flush while a fetch word is offered and the buffer is full, and judges that neither the consumption nor the word survives. Expected slot contents are written out from the requirements for each of these cycles.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;

    localparam int SLOT_NUM = 3;
    localparam int CNT_W    = $clog2(SLOT_NUM + 1);

    typedef enum logic [2:0] {
        OCC_EMPTY       = 3'd0,
        OCC_ONE         = 3'd1,
        OCC_TWO_PLAIN   = 3'd2,
        OCC_TWO_PFX     = 3'd3,
        OCC_THREE_PLAIN = 3'd4,
        OCC_THREE_PFX   = 3'd5
    } occ_e;

endpackage

// File: rtl/ibuf_prefix_detect.sv
module ibuf_prefix_detect #(
    parameter int               ILEN      = 16,
    parameter logic [ILEN-1:0]  PFX_MASK  = 16'hFF00,
    parameter logic [ILEN-1:0]  PFX_MATCH = 16'hDE00
) (
    input  logic [ILEN-1:0] instr,
    output logic            is_pfx
);

    assign is_pfx = ((instr & PFX_MASK) == PFX_MATCH);

endmodule

// File: rtl/ibuf_occ_fsm.sv
module ibuf_occ_fsm
    import ibuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             accept,
    input  logic [CNT_W-1:0] nxt_cnt,
    input  logic             nxt_pfx,
    output occ_e             state,
    output logic [CNT_W-1:0] cur_cnt,
    output logic [CNT_W-1:0] take_cnt,
    output logic [CNT_W-1:0] remain_cnt,
    output logic             fetch_req,
    output logic             pair_take
);

    occ_e state_q;
    occ_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from the current state
    always_comb begin
        cur_cnt   = '0;
        take_cnt  = '0;
        pair_take = 1'b0;
        unique case (state_q)
            OCC_EMPTY: begin
            end
            OCC_ONE: begin
                cur_cnt  = CNT_W'(1);
                take_cnt = CNT_W'(1);
            end
            OCC_TWO_PLAIN: begin
                cur_cnt  = CNT_W'(2);
                take_cnt = CNT_W'(1);
            end
            OCC_TWO_PFX: begin
                cur_cnt   = CNT_W'(2);
                take_cnt  = CNT_W'(2);
                pair_take = 1'b1;
            end
            OCC_THREE_PLAIN: begin
                cur_cnt  = CNT_W'(3);
                take_cnt = CNT_W'(1);
            end
            OCC_THREE_PFX: begin
                cur_cnt   = CNT_W'(3);
                take_cnt  = CNT_W'(2);
                pair_take = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign remain_cnt = cur_cnt - take_cnt;
    assign fetch_req  = (remain_cnt <= CNT_W'(1));
    assign state      = state_q;

    // next state: flush wins, otherwise pick by new count and new slot 2
    always_comb begin
        if (flush) begin
            state_d = OCC_EMPTY;
        end else begin
            unique case (nxt_cnt)
                CNT_W'(0): state_d = OCC_EMPTY;
                CNT_W'(1): state_d = OCC_ONE;
                CNT_W'(2): state_d = nxt_pfx ? OCC_TWO_PFX : OCC_TWO_PLAIN;
                default:   state_d = nxt_pfx ? OCC_THREE_PFX : OCC_THREE_PLAIN;
            endcase
        end
    end

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state_q == OCC_EMPTY));

    // R7
    deposit_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !flush) |=> (cur_cnt >= CNT_W'(2)));

    // R5
    pair_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_TWO_PFX && !accept && !flush) |=> (state_q == OCC_EMPTY));

    // R6
    full_no_deposit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_THREE_PLAIN && !flush) |=> (cur_cnt == CNT_W'(2)));

    // R10
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_EMPTY && !accept) |=> (state_q == OCC_EMPTY));

endmodule

// File: rtl/ibuf_slot_shift.sv
module ibuf_slot_shift
    import ibuf_pkg::*;
#(
    parameter int ILEN = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             accept,
    input  logic [2*ILEN-1:0]                word,
    input  logic [CNT_W-1:0]                 take_cnt,
    input  logic [CNT_W-1:0]                 remain_cnt,
    output logic [SLOT_NUM-1:0][ILEN-1:0]    slots,
    output logic [SLOT_NUM-1:0][ILEN-1:0]    nxt_slots,
    output logic [CNT_W-1:0]                 nxt_cnt
);

    localparam int WORD_HALVES = 2;

    assign nxt_cnt = remain_cnt + (accept ? CNT_W'(WORD_HALVES) : CNT_W'(0));

    for (genvar g = 0; g < SLOT_NUM; g++) begin : g_slot
        localparam int SRC1 = (g + 1 < SLOT_NUM) ? g + 1 : g;
        localparam int SRC2 = (g + 2 < SLOT_NUM) ? g + 2 : g;

        logic [ILEN-1:0] q;
        logic [ILEN-1:0] d;

        always_comb begin
            d = q;
            if (CNT_W'(g) < remain_cnt) begin
                if (take_cnt == CNT_W'(2)) begin
                    d = slots[SRC2];
                end else if (take_cnt == CNT_W'(1)) begin
                    d = slots[SRC1];
                end else begin
                    d = q;
                end
            end else if (accept && remain_cnt == CNT_W'(g)) begin
                d = word[ILEN-1:0];
            end else if (accept && (g >= 1) && remain_cnt == CNT_W'(g - 1)) begin
                d = word[2*ILEN-1:ILEN];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                q <= d;
            end
        end

        assign slots[g]     = q;
        assign nxt_slots[g] = d;
    end

endmodule

// File: rtl/lookahead_ibuf.sv
module lookahead_ibuf
    import ibuf_pkg::*;
#(
    parameter int              ILEN      = 16,
    parameter logic [ILEN-1:0] PFX_MASK  = 16'hFF00,
    parameter logic [ILEN-1:0] PFX_MATCH = 16'hDE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              fetch_valid_i,
    input  logic [2*ILEN-1:0] fetch_word_i,
    output logic              fetch_req_o,
    output logic              slot1_valid_o,
    output logic [ILEN-1:0]   slot1_instr_o,
    output logic              slot2_valid_o,
    output logic [ILEN-1:0]   slot2_instr_o,
    output logic              pair_take_o
);

    occ_e                          state;
    logic [CNT_W-1:0]              cur_cnt;
    logic [CNT_W-1:0]              take_cnt;
    logic [CNT_W-1:0]              remain_cnt;
    logic [CNT_W-1:0]              nxt_cnt;
    logic                          nxt_pfx;
    logic                          accept;
    logic [SLOT_NUM-1:0][ILEN-1:0] slots;
    logic [SLOT_NUM-1:0][ILEN-1:0] nxt_slots;

    assign accept = fetch_valid_i && fetch_req_o;

    ibuf_occ_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush_i),
        .accept     (accept),
        .nxt_cnt    (nxt_cnt),
        .nxt_pfx    (nxt_pfx),
        .state      (state),
        .cur_cnt    (cur_cnt),
        .take_cnt   (take_cnt),
        .remain_cnt (remain_cnt),
        .fetch_req  (fetch_req_o),
        .pair_take  (pair_take_o)
    );

    ibuf_slot_shift #(.ILEN(ILEN)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .word       (fetch_word_i),
        .take_cnt   (take_cnt),
        .remain_cnt (remain_cnt),
        .slots      (slots),
        .nxt_slots  (nxt_slots),
        .nxt_cnt    (nxt_cnt)
    );

    ibuf_prefix_detect #(
        .ILEN      (ILEN),
        .PFX_MASK  (PFX_MASK),
        .PFX_MATCH (PFX_MATCH)
    ) u_pfx (
        .instr  (nxt_slots[1]),
        .is_pfx (nxt_pfx)
    );

    assign slot1_valid_o = (cur_cnt >= CNT_W'(1));
    assign slot2_valid_o = (cur_cnt >= CNT_W'(2));
    assign slot1_instr_o = slots[0];
    assign slot2_instr_o = slots[1];

    // R4
    single_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot2_valid_o && !pair_take_o && !flush_i) |=> (slot1_instr_o == $past(slot2_instr_o)));

    // R2
    pair_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_take_o |-> (slot2_valid_o && state != OCC_EMPTY));

endmodule

// File: tb/lookahead_ibuf_bench.sv
module lookahead_ibuf_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        fetch_valid_i = 1'b0;
    logic [31:0] fetch_word_i = '0;
    logic        fetch_req_o;
    logic        slot1_valid_o;
    logic [15:0] slot1_instr_o;
    logic        slot2_valid_o;
    logic [15:0] slot2_instr_o;
    logic        pair_take_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lookahead_ibuf u_lookahead_ibuf (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_i       (flush_i),
        .fetch_valid_i (fetch_valid_i),
        .fetch_word_i  (fetch_word_i),
        .fetch_req_o   (fetch_req_o),
        .slot1_valid_o (slot1_valid_o),
        .slot1_instr_o (slot1_instr_o),
        .slot2_valid_o (slot2_valid_o),
        .slot2_instr_o (slot2_instr_o),
        .pair_take_o   (pair_take_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic drive(input logic fl, input logic fv, input logic [31:0] w);
        flush_i       = fl;
        fetch_valid_i = fv;
        fetch_word_i  = w;
    endtask

    task automatic clear_buf();
        drive(1'b1, 1'b0, '0);
        tick();
        drive(1'b0, 1'b0, '0);
    endtask

    task automatic t_reset();
        chk("R1", "slot1_valid", 32'(slot1_valid_o), 32'd0);
        chk("R1", "slot2_valid", 32'(slot2_valid_o), 32'd0);
        chk("R1", "pair_take",   32'(pair_take_o),   32'd0);
        chk("R1", "fetch_req",   32'(fetch_req_o),   32'd1);
    endtask

    task automatic t_stream();
        clear_buf();
        drive(1'b0, 1'b1, {16'h1002, 16'h1001});
        tick();
        chk("R3", "slot1", 32'(slot1_instr_o), 32'h1001);
        chk("R3", "slot2", 32'(slot2_instr_o), 32'h1002);
        chk("R2", "pair_take plain", 32'(pair_take_o), 32'd0);
        chk("R6", "req with one left", 32'(fetch_req_o), 32'd1);
        // single consume with top-up into slots 2 and 3
        drive(1'b0, 1'b1, {16'h1004, 16'h1003});
        tick();
        chk("R4", "slot1 after single", 32'(slot1_instr_o), 32'h1002);
        chk("R7", "slot2 top-up", 32'(slot2_instr_o), 32'h1003);
        chk("R6", "req with two left", 32'(fetch_req_o), 32'd0);
        // offered word while full is ignored
        drive(1'b0, 1'b1, {16'h1006, 16'h1005});
        tick();
        chk("R7", "slot1 from slot3 path", 32'(slot1_instr_o), 32'h1003);
        chk("R7", "slot2 upper half", 32'(slot2_instr_o), 32'h1004);
        drive(1'b0, 1'b0, '0);
        tick();
        chk("R6", "ignored word not present", 32'(slot1_instr_o), 32'h1004);
        chk("R10", "one left slot2_valid", 32'(slot2_valid_o), 32'd0);
        tick();
        chk("R10", "drained slot1_valid", 32'(slot1_valid_o), 32'd0);
        tick();
        chk("R10", "stays empty", 32'(slot1_valid_o), 32'd0);
        chk("R10", "req when empty", 32'(fetch_req_o), 32'd1);
    endtask

    task automatic t_prefix();
        clear_buf();
        drive(1'b0, 1'b1, {16'hDE05, 16'h2001});
        tick();
        chk("R2", "pair_take on prefix", 32'(pair_take_o), 32'd1);
        chk("R6", "req during pair", 32'(fetch_req_o), 32'd1);
        drive(1'b0, 1'b1, {16'h2003, 16'h2002});
        tick();
        chk("R5", "refill slot1", 32'(slot1_instr_o), 32'h2002);
        chk("R5", "refill slot2", 32'(slot2_instr_o), 32'h2003);
        chk("R2", "pair_take clear", 32'(pair_take_o), 32'd0);
        drive(1'b0, 1'b1, {16'h2005, 16'hDE07});
        tick();
        chk("R4", "slot1 single", 32'(slot1_instr_o), 32'h2003);
        chk("R2", "prefix in slot2 of three", 32'(pair_take_o), 32'd1);
        chk("R6", "req with one surviving", 32'(fetch_req_o), 32'd1);
        // pair consume while depositing behind old slot 3
        drive(1'b0, 1'b1, {16'h2007, 16'h2006});
        tick();
        chk("R5", "old slot3 to slot1", 32'(slot1_instr_o), 32'h2005);
        chk("R5", "new lower to slot2", 32'(slot2_instr_o), 32'h2006);
        chk("R2", "no pair after", 32'(pair_take_o), 32'd0);
        drive(1'b0, 1'b0, '0);
        tick();
        chk("R7", "new upper reached slot2", 32'(slot2_instr_o), 32'h2007);
    endtask

    task automatic t_flush();
        clear_buf();
        drive(1'b0, 1'b1, {16'h3002, 16'h3001});
        tick();
        drive(1'b0, 1'b1, {16'h3004, 16'h3003});
        tick();
        // full buffer, flush with a word offered
        drive(1'b1, 1'b1, {16'h3006, 16'h3005});
        tick();
        chk("R8", "slot1_valid after flush", 32'(slot1_valid_o), 32'd0);
        chk("R8", "slot2_valid after flush", 32'(slot2_valid_o), 32'd0);
        chk("R8", "req after flush", 32'(fetch_req_o), 32'd1);
        drive(1'b0, 1'b1, {16'h3008, 16'hDE33});
        tick();
        chk("R9", "prefix-coded in slot1", 32'(slot1_instr_o), 32'hDE33);
        chk("R9", "no pair from slot1", 32'(pair_take_o), 32'd0);
        drive(1'b0, 1'b0, '0);
        tick();
        chk("R9", "only one taken", 32'(slot1_instr_o), 32'h3008);
        chk("R9", "slot1 still valid", 32'(slot1_valid_o), 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_stream();
        t_prefix();
        t_flush();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule